// File: doc/BRIEF.md
# Two-World Split-Line Region Guard

This block checks accesses to a small retention SRAM window that two security worlds share. Each world owns one movable boundary. The boundary is kept as a word offset, so it falls on a 4-byte step. It divides the window into a lower part and an upper part. Each part carries its own three permission bits (read, write, fetch) per world. On every access the world tag picks the boundary and the permission pair that apply. The block then answers allow or deny.

Configuration arrives over a plain write port. A write names what to update: a boundary, a permission field, or the lock. It also names the world and, for permissions, the part. A write touches only the named world's bits. A boundary address that is misaligned or outside the window is dropped. Writing 1 to the lock freezes every setting until reset. Accesses outside the window pass through as allowed and are flagged as not in the window.

Accesses enter through a valid/ready stream and results leave through one. An access is taken on a rising edge where `acc_valid` and `acc_ready` are both high. Its result is presented from the next cycle. `acc_ready` is high whenever the single result slot is empty or being drained. A result stays stable while `res_valid` is high and `res_ready` is low.

Top module: `dwg_region_guard`

## Requirements
- R1: After reset `res_valid` is 0, the lock is open, every boundary is 0 and every permission field is 0, so any in-window access is denied.
- R2: For an in-window access, the word offset (address minus window base, shifted right by 2) is compared with the world's boundary. An offset below the boundary uses the lower-part permissions. An offset at or above it uses the upper-part permissions.
- R3: Permission bit 0 grants read, bit 1 grants write and bit 2 grants fetch. `acc_kind` 0 is read, 1 is write and 2 is fetch. Kind 3 is always denied inside the window.
- R4: `acc_world` 0 and 1 each select their own boundary and permissions. An in-window access with `acc_world` 2 or 3 is denied.
- R5: An address outside the window gives `res_allow`=1 and `res_in_region`=0. An address inside gives `res_in_region`=1.
- R6: A boundary write (`cfg_op`=0) takes `cfg_wdata` as a byte address. It stores (address - base) >> 2 only if the address is a multiple of 4, at or above the base, and below base + window size. Otherwise the write is ignored.
- R7: A boundary or permission write whose `cfg_world` is 2 or 3 is ignored.
- R8: A permission write (`cfg_op`=1) replaces only the selected world's lower part (`cfg_area`=0) or upper part (`cfg_area`=1) with `cfg_wdata[2:0]`. A write to one world leaves the other world's boundary and permissions unchanged.
- R9: A lock write (`cfg_op`=2) with `cfg_wdata[0]`=1 sets the lock. If `cfg_wdata[0]`=0 the lock write has no effect. Once locked, all configuration writes are ignored until reset.
- R10: Each accepted access yields exactly one result, in order, starting the cycle after acceptance. `acc_ready` = !`res_valid` || `res_ready`. A stalled result holds steady.
- R11: Base + window size - 4 is the last in-window word. Base + window size is outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | 0 boundary, 1 permission, 2 lock, 3 no operation |
| cfg_world | input | 2 | World addressed by the write |
| cfg_area | input | 1 | Permission part: 0 lower, 1 upper |
| cfg_wdata | input | ADDR_W | Boundary byte address, permission bits [2:0], or lock bit [0] |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Guard can take an access |
| acc_addr | input | ADDR_W | Access byte address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| acc_world | input | 2 | World tag of the access |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_allow | output | 1 | 1 = access permitted |
| res_in_region | output | 1 | 1 = address inside the guarded window |

## Verification
Several properties are checked on every cycle:
- the lock, once set, stays set;
- settings stay frozen while locked;
- writes tagged with an unknown world change nothing;
- a write to one world leaves the other world's fields alone;
- a stalled result holds;
- out-of-window addresses pass;
- unknown worlds and reserved kinds are denied.

Other behaviour needs the bench's scenarios. These cover the choice between the lower and upper part at the exact boundary word and the last word of the window. They also cover rejection of misaligned and out-of-window boundary writes, an ineffective lock write, and result ordering under back-pressure.

// File: rtl/dwg_pkg.sv
package dwg_pkg;
  localparam int NUM_WORLDS = 2;
  localparam int PERM_W     = 3;
  localparam int PB_READ    = 0;
  localparam int PB_WRITE   = 1;
  localparam int PB_FETCH   = 2;

  typedef enum logic [1:0] {
    OP_SPLIT = 2'd0,
    OP_PERM  = 2'd1,
    OP_LOCK  = 2'd2,
    OP_NONE  = 2'd3
  } cfg_op_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/dwg_cfg_regs.sv
module dwg_cfg_regs
  import dwg_pkg::*;
#(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = 32'h5000_0000,
  parameter int                BYTES  = 8192,
  parameter int                OFF_W  = $clog2(BYTES) - 2,
  parameter int                NW     = NUM_WORLDS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [1:0]             cfg_op,
  input  logic [1:0]             cfg_world,
  input  logic                   cfg_area,
  input  logic [ADDR_W-1:0]      cfg_wdata,
  output logic [NW*OFF_W-1:0]    split_o,
  output logic [NW*PERM_W-1:0]   perm_lo_o,
  output logic [NW*PERM_W-1:0]   perm_hi_o,
  output logic                   locked_o
);
  localparam logic [ADDR_W:0] END_ADDR = {1'b0, BASE} + (ADDR_W+1)'(BYTES);

  logic [NW*OFF_W-1:0]  split_q;
  logic [NW*PERM_W-1:0] lo_q, hi_q;
  logic                 lock_q;
  logic                 addr_ok;
  logic [OFF_W-1:0]     new_off;

  // base is aligned to the window size, so the word offset is a plain slice
  assign addr_ok = ({1'b0, cfg_wdata} >= {1'b0, BASE}) &&
                   ({1'b0, cfg_wdata} < END_ADDR) && (cfg_wdata[1:0] == 2'b00);
  assign new_off = cfg_wdata[OFF_W+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      split_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      lock_q  <= 1'b0;
    end else if (cfg_wr && !lock_q) begin
      for (int w = 0; w < NW; w++) begin
        if (int'(cfg_world) == w) begin
          if (cfg_op == OP_SPLIT && addr_ok)
            split_q[w*OFF_W +: OFF_W] <= new_off;
          if (cfg_op == OP_PERM && !cfg_area)
            lo_q[w*PERM_W +: PERM_W] <= cfg_wdata[PERM_W-1:0];
          if (cfg_op == OP_PERM && cfg_area)
            hi_q[w*PERM_W +: PERM_W] <= cfg_wdata[PERM_W-1:0];
        end
      end
      if (cfg_op == OP_LOCK && cfg_wdata[0])
        lock_q <= 1'b1;
    end
  end

  assign split_o   = split_q;
  assign perm_lo_o = lo_q;
  assign perm_hi_o = hi_q;
  assign locked_o  = lock_q;

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  assert_frozen_when_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(split_q) && $stable(lo_q) && $stable(hi_q)));
  assert_bad_world_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && int'(cfg_world) >= NW) |=>
      ($stable(split_q) && $stable(lo_q) && $stable(hi_q)));
  assert_other_world_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_world == 2'd0) |=>
      ($stable(split_q[(NW-1)*OFF_W +: OFF_W]) &&
       $stable(lo_q[(NW-1)*PERM_W +: PERM_W]) &&
       $stable(hi_q[(NW-1)*PERM_W +: PERM_W])));
endmodule

// File: rtl/dwg_check.sv
module dwg_check
  import dwg_pkg::*;
#(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = 32'h5000_0000,
  parameter int                BYTES  = 8192,
  parameter int                OFF_W  = $clog2(BYTES) - 2,
  parameter int                NW     = NUM_WORLDS
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           kind_i,
  input  logic [1:0]           world_i,
  input  logic [NW*OFF_W-1:0]  split_i,
  input  logic [NW*PERM_W-1:0] perm_lo_i,
  input  logic [NW*PERM_W-1:0] perm_hi_i,
  output logic                 allow_o,
  output logic                 in_region_o
);
  localparam logic [ADDR_W:0] END_ADDR = {1'b0, BASE} + (ADDR_W+1)'(BYTES);

  logic [OFF_W-1:0] off;
  logic [NW-1:0]    ok;
  logic             sel_ok;

  assign in_region_o = ({1'b0, addr_i} >= {1'b0, BASE}) && ({1'b0, addr_i} < END_ADDR);
  assign off = addr_i[OFF_W+1:2];

  for (genvar w = 0; w < NW; w++) begin : g_world
    logic [OFF_W-1:0]  bound;
    logic [PERM_W-1:0] eff;
    assign bound = split_i[w*OFF_W +: OFF_W];
    assign eff   = (off < bound) ? perm_lo_i[w*PERM_W +: PERM_W]
                                 : perm_hi_i[w*PERM_W +: PERM_W];
    always_comb begin
      case (kind_i)
        ACC_READ:  ok[w] = eff[PB_READ];
        ACC_WRITE: ok[w] = eff[PB_WRITE];
        ACC_FETCH: ok[w] = eff[PB_FETCH];
        default:   ok[w] = 1'b0;
      endcase
    end
  end

  always_comb begin
    sel_ok = 1'b0;
    for (int w = 0; w < NW; w++)
      if (int'(world_i) == w) sel_ok = ok[w];
  end

  assign allow_o = !in_region_o || sel_ok;
endmodule

// File: rtl/dwg_out_stage.sv
module dwg_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_allow,
  input  logic in_inreg,
  output logic out_valid,
  input  logic out_ready,
  output logic out_allow,
  output logic out_inreg
);
  logic v_q, allow_q, inreg_q;

  assign in_ready = !v_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      allow_q <= 1'b0;
      inreg_q <= 1'b0;
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) begin
        allow_q <= in_allow;
        inreg_q <= in_inreg;
      end
    end
  end

  assign out_valid = v_q;
  assign out_allow = allow_q;
  assign out_inreg = inreg_q;

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !out_ready) |=> (v_q && $stable(allow_q) && $stable(inreg_q)));
endmodule

// File: rtl/dwg_region_guard.sv
module dwg_region_guard
  import dwg_pkg::*;
#(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = 32'h5000_0000,
  parameter int                BYTES  = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_op,
  input  logic [1:0]        cfg_world,
  input  logic              cfg_area,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        acc_world,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_allow,
  output logic              res_in_region
);
  localparam int OFF_W = $clog2(BYTES) - 2;
  localparam int NW    = NUM_WORLDS;

  logic [NW*OFF_W-1:0]  split;
  logic [NW*PERM_W-1:0] perm_lo, perm_hi;
  logic                 locked;
  logic                 chk_allow, chk_inreg;

  dwg_cfg_regs #(.ADDR_W(ADDR_W), .BASE(BASE), .BYTES(BYTES), .OFF_W(OFF_W), .NW(NW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_op(cfg_op), .cfg_world(cfg_world),
    .cfg_area(cfg_area), .cfg_wdata(cfg_wdata), .split_o(split), .perm_lo_o(perm_lo),
    .perm_hi_o(perm_hi), .locked_o(locked)
  );

  dwg_check #(.ADDR_W(ADDR_W), .BASE(BASE), .BYTES(BYTES), .OFF_W(OFF_W), .NW(NW)) u_chk (
    .addr_i(acc_addr), .kind_i(acc_kind), .world_i(acc_world), .split_i(split),
    .perm_lo_i(perm_lo), .perm_hi_i(perm_hi), .allow_o(chk_allow), .in_region_o(chk_inreg)
  );

  dwg_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(acc_valid), .in_ready(acc_ready),
    .in_allow(chk_allow), .in_inreg(chk_inreg), .out_valid(res_valid),
    .out_ready(res_ready), .out_allow(res_allow), .out_inreg(res_in_region)
  );

  assert_outside_allowed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_addr < BASE) |=>
      (res_valid && res_allow && !res_in_region));
  assert_bad_world_denied_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && int'(acc_world) >= NW) |=>
      (res_valid && (!res_in_region || !res_allow)));
  assert_rsvd_kind_denied_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_kind == ACC_RSVD) |=>
      (res_valid && (!res_in_region || !res_allow)));
  assert_locked_unused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

// File: tb/dwg_region_guard_tb.sv
`timescale 1ns/1ps
module dwg_region_guard_tb;
  localparam logic [31:0] BASE  = 32'h5000_0000;
  localparam int          BYTES = 8192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0; logic [1:0] cfg_op = 3, cfg_world = 0; logic cfg_area = 0;
  logic [31:0] cfg_wdata = 0;
  logic acc_valid = 0, acc_ready; logic [31:0] acc_addr = 0;
  logic [1:0] acc_kind = 0, acc_world = 0;
  logic res_valid, res_ready = 1, res_allow, res_in_region;

  int checks = 0, errors = 0, cyc = 0;
  bit stall_en = 0, done = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  // bench model of the configuration
  int  split_m[2];
  logic [2:0] lo_m[2], hi_m[2];
  bit  lock_m = 0;

  always #2.5 clk = ~clk;

  dwg_region_guard #(.ADDR_W(32), .BASE(BASE), .BYTES(BYTES)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_op(cfg_op), .cfg_world(cfg_world),
    .cfg_area(cfg_area), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_world(acc_world), .res_valid(res_valid),
    .res_ready(res_ready), .res_allow(res_allow), .res_in_region(res_in_region)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [31:0] a, input logic [1:0] k,
                                        input logic [1:0] w);
    bit inr; logic [2:0] p; bit ok;
    inr = (a >= BASE) && (a < BASE + BYTES);
    if (!inr) return 2'b01;               // {in_region, allow}
    if (w > 1) return 2'b10;
    p = (int'((a - BASE) >> 2) < split_m[w]) ? lo_m[w] : hi_m[w];
    case (k)
      2'd0: ok = p[0];
      2'd1: ok = p[1];
      2'd2: ok = p[2];
      default: ok = 0;
    endcase
    return {1'b1, ok};
  endfunction

  task automatic cfg(input logic [1:0] op, input logic [1:0] w, input bit area,
                     input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_op = op; cfg_world = w; cfg_area = area; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_op = 3;
    if (!lock_m) begin
      case (op)
        2'd0: if (w < 2 && d >= BASE && d < BASE + BYTES && d[1:0] == 0)
                split_m[w] = int'((d - BASE) >> 2);
        2'd1: if (w < 2) begin if (area) hi_m[w] = d[2:0]; else lo_m[w] = d[2:0]; end
        2'd2: if (d[0]) lock_m = 1;
        default: ;
      endcase
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [1:0] k, input logic [1:0] w,
                      input string tag);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_kind = k; acc_world = w;
    #1;
    while (!acc_ready) begin @(negedge clk); #1; end
    exp_q.push_back(model(a, k, w));
    tag_q.push_back(tag);
    @(negedge clk);
    acc_valid = 0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      res_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
      #0.5;
      if (rst_n && res_valid && res_ready) begin
        if (exp_q.size() == 0) check(0, "R10 unexpected result", 1, 0);
        else begin
          logic [1:0] e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check({res_in_region, res_allow} == e, t, {res_in_region, res_allow}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    split_m = '{0, 0}; lo_m = '{0, 0}; hi_m = '{0, 0};
    repeat (3) @(negedge clk);
    check(res_valid == 0, "R1 res_valid after reset", res_valid, 0);
    rst_n = 1;
    @(negedge clk); #1;
    check(acc_ready == 1, "R10 ready when empty", acc_ready, 1);
    send(BASE + 32'h40, 0, 0, "R1 in-window denied after reset");
    send(BASE - 4, 1, 0, "R5 below window allowed");

    cfg(0, 0, 0, BASE + 32'h100);   // world0 boundary at word 0x40
    cfg(1, 0, 0, 32'd5);            // world0 lower: read+fetch
    cfg(1, 0, 1, 32'd3);            // world0 upper: read+write
    cfg(0, 1, 0, BASE + 32'h1000);
    cfg(1, 1, 0, 32'd2);            // world1 lower: write
    cfg(1, 1, 1, 32'd7);
    send(BASE + 32'hFC,  0, 0, "R2 lower read");
    send(BASE + 32'hFC,  1, 0, "R2 lower write denied");
    send(BASE + 32'h100, 1, 0, "R2 boundary word uses upper");
    send(BASE + 32'h100, 2, 0, "R3 fetch denied upper");
    send(BASE + 32'hFC,  2, 0, "R3 fetch allowed lower");
    send(BASE + 32'h100, 2, 1, "R4 world1 own lower");
    send(BASE + 32'h100, 1, 1, "R4 world1 write");
    send(BASE + 32'h100, 0, 2, "R4 unknown world denied");
    send(BASE + 32'h100, 3, 0, "R3 reserved kind denied");
    send(BASE + BYTES - 4, 2, 1, "R11 last word in window");
    send(BASE + BYTES, 0, 0, "R11 end address outside");

    cfg(0, 0, 0, BASE + 32'h202);   // misaligned
    send(BASE + 32'h100, 1, 0, "R6 misaligned boundary ignored");
    cfg(0, 0, 0, BASE + BYTES);     // out of range
    send(BASE + 32'hFC, 1, 0, "R6 out-of-range boundary ignored");
    cfg(0, 0, 0, BASE - 32'h200);
    send(BASE + 32'hFC, 1, 0, "R6 below-base boundary ignored");

    cfg(1, 2, 0, 32'd7);
    send(BASE + 32'hFC, 1, 0, "R7 unknown-world perm write ignored");
    cfg(0, 3, 0, BASE + 32'h800);
    send(BASE + 32'hFFC, 2, 1, "R7 unknown-world boundary write ignored");

    cfg(0, 0, 0, BASE + 32'h800);
    send(BASE + 32'h7FC, 1, 0, "R8 world0 new boundary");
    send(BASE + 32'hFFC, 2, 1, "R8 world1 boundary kept");
    cfg(1, 1, 1, 32'd0);
    send(BASE + 32'h800, 1, 0, "R8 world0 upper kept");
    send(BASE + 32'h1000, 0, 1, "R8 world1 upper replaced");

    stall_en = 1;
    for (int i = 0; i < 8; i++)
      send(BASE + 32'h7F8 + 4*i, 2'(i % 3), 1'(i % 2), "R10 ordered under back-pressure");
    stall_en = 0;

    cfg(2, 0, 0, 32'd0);            // no lock
    cfg(1, 0, 0, 32'd2);
    send(BASE + 32'h10, 1, 0, "R9 lock write of 0 has no effect");
    cfg(2, 0, 0, 32'd1);
    cfg(0, 0, 0, BASE);
    cfg(1, 0, 0, 32'd0);
    send(BASE + 32'h10, 1, 0, "R9 writes ignored when locked");
    send(BASE + 32'h800, 1, 0, "R9 boundary frozen");

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R10 all results returned", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule